// File: doc/BRIEF.md
# Stack, Call and Return Unit

This block holds the stack pointer and the flag byte of a small 8-bit processor and carries out every operation that touches the stack through one byte-wide memory port. A decoder hands it one command at a time together with a register value, an 8-bit immediate and a return address. The unit runs the memory accesses the command needs, moves the stack pointer, and hands back a register result or a new program counter with a one-cycle strobe.

The supported operations are byte push and pop of a register or of the whole flag byte, subroutine call and return with 16-bit addresses, interrupt return, loads and stores relative to the stack pointer, and an exchange that moves the stack onto a new 256-byte page. Return addresses sit in memory with the high byte at the lower address. Memory reads return after a fixed number of cycles that is set by a parameter. Reads may be issued back to back before the first data arrives.

Top module: `stk_unit`

## Requirements
- R1: Command code 1 (push register) first lowers SP by one and then writes cmd_reg to memory at the new SP.
- R2: Command code 2 (pop register) reads the byte at SP, returns it on reg_out with reg_we high, and leaves SP one higher.
- R3: Command code 5 (call) writes the low byte of cmd_ret to SP-1 and then the high byte to SP-2, in that order, and leaves SP two lower.
- R4: Command code 6 (return) drives pc_out with {mem[SP], mem[SP+1]} (high byte from the lower address) and pc_we high, and leaves SP two higher.
- R5: Command code 7 (interrupt return) behaves as R4 and also sets flag bit 4 (interrupt enable), leaving the other flag bits unchanged.
- R6: Command code 8 (page exchange) loads SP with {cmd_reg, 8'h00} and returns the old SP bits 15:8 on reg_out with reg_we high.
- R7: Command codes 9 (load) and 10 (store) access address SP plus cmd_imm zero-extended to 16 bits. Load returns the byte on reg_out and store writes cmd_reg. Neither changes SP.
- R8: After reset SP is 0x0000 and flags_out is 0x10 (only bit 4 set), and busy, done, reg_we, pc_we, mem_we and mem_re are low.
- R9: Command code 3 pushes the whole flag byte as in R1 and command code 4 pops a byte into the whole flag register as in R2.
- R10: All SP arithmetic wraps modulo 65536. A push at SP 0x0000 writes address 0xFFFF, and a pop at 0xFFFF leaves SP at 0x0000.
- R11: A command is taken only when cmd_valid is high and busy is low, and commands offered while busy are ignored. done is a one-cycle pulse aligned with reg_we and pc_we, and busy is low in that cycle. Command code 0 and codes 11 to 15 only produce done.
- R12: Read data on mem_rdata is taken RD_LAT cycles after the cycle in which mem_re was high, and a second read may be issued before the first returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 4 | Command code |
| cmd_reg | input | DATA_W | Register operand |
| cmd_imm | input | DATA_W | Unsigned offset for SP-relative access |
| cmd_ret | input | ADDR_W | Return address to store on call |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_out | output | DATA_W | Register result |
| reg_we | output | 1 | reg_out is valid |
| pc_out | output | ADDR_W | Program counter from return |
| pc_we | output | 1 | pc_out is valid |
| flags_out | output | DATA_W | Current flag byte |
| sp_out | output | ADDR_W | Current stack pointer |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, RD_LAT cycles after mem_re |

## Verification
The bench builds the unit with DATA_W 8, ADDR_W 16 and interrupt-enable bit 4, and sets RD_LAT to 2 rather than the default 1. With a two-cycle read latency, the second read of a return is issued while the first read is still in flight. The bench can then show that the high and low bytes are paired in order and that completion waits for the last byte. The 16-bit pointer lets the bench cross the 0x0000/0xFFFF boundary, exchange onto the top page, and show that the offset is zero-extended at 0xFF00 + 0xFF.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [3:0] {
      OP_NOP    = 4'd0,
      OP_PUSH_R = 4'd1,
      OP_POP_R  = 4'd2,
      OP_PUSH_F = 4'd3,
      OP_POP_F  = 4'd4,
      OP_CALL   = 4'd5,
      OP_RET    = 4'd6,
      OP_IRET   = 4'd7,
      OP_XCHG   = 4'd8,
      OP_LD_REL = 4'd9,
      OP_ST_REL = 4'd10
   } stk_op_e;

   typedef enum logic [1:0] {
      SP_HOLD,
      SP_DEC,
      SP_INC,
      SP_LOAD
   } sp_act_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_DRAIN
   } stk_state_e;

   // memory accesses issued by an operation
   function automatic logic [1:0] op_accesses(stk_op_e op);
      case (op)
         OP_PUSH_R, OP_POP_R, OP_PUSH_F, OP_POP_F,
         OP_LD_REL, OP_ST_REL:          return 2'd1;
         OP_CALL, OP_RET, OP_IRET:      return 2'd2;
         default:                       return 2'd0;
      endcase
   endfunction

   // how many of those accesses are reads
   function automatic logic [1:0] op_reads(stk_op_e op);
      case (op)
         OP_POP_R, OP_POP_F, OP_LD_REL: return 2'd1;
         OP_RET, OP_IRET:               return 2'd2;
         default:                       return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/stk_sp_reg.sv
module stk_sp_reg
   import stk_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sp_act_e           act,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] sp_q
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else begin
         case (act)
            SP_DEC:  sp_q <= sp_q - ONE;
            SP_INC:  sp_q <= sp_q + ONE;
            SP_LOAD: sp_q <= load_val;
            default: sp_q <= sp_q;
         endcase
      end
   end

   // R10
   wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == SP_INC && sp_q == '1) |=> (sp_q == '0));

endmodule

// File: rtl/stk_flag_reg.sv
module stk_flag_reg #(
   parameter int                DATA_W  = 8,
   parameter int                IE_BIT  = 4,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              set_ie,
   output logic [DATA_W-1:0] flags_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= RST_VAL;
      end else if (load) begin
         flags_q <= load_val;
      end else if (set_ie) begin
         flags_q[IE_BIT] <= 1'b1;
      end
   end

endmodule

// File: rtl/stk_rd_pipe.sv
module stk_rd_pipe #(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic ret_vld
);

   generate
      if (RD_LAT == 1) begin : g_single
         logic vld_q;
         always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= issue;
         end
         assign ret_vld = vld_q;
      end else begin : g_shift
         logic [RD_LAT-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[RD_LAT-2:0], issue};
         end
         assign ret_vld = sh_q[RD_LAT-1];
      end
   endgenerate

endmodule

// File: rtl/stk_unit.sv
module stk_unit
   import stk_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int IE_BIT = 4,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_reg,
   input  logic [DATA_W-1:0] cmd_imm,
   input  logic [ADDR_W-1:0] cmd_ret,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] reg_out,
   output logic              reg_we,
   output logic [ADDR_W-1:0] pc_out,
   output logic              pc_we,
   output logic [DATA_W-1:0] flags_out,
   output logic [ADDR_W-1:0] sp_out,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam logic [DATA_W-1:0] FLAG_RST = DATA_W'(1) << IE_BIT;
   localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("stk_unit: ADDR_W must be twice DATA_W");
      end
      if (IE_BIT < 0 || IE_BIT >= DATA_W) begin : g_bad_ie
         $error("stk_unit: IE_BIT outside the flag byte");
      end
      if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_lat
         $error("stk_unit: RD_LAT must lie in 1..8");
      end
   endgenerate

   stk_state_e        state_q;
   stk_op_e           op_q;
   logic [DATA_W-1:0] reg_q;
   logic [DATA_W-1:0] imm_q;
   logic [ADDR_W-1:0] ret_q;
   logic [1:0]        step_q;
   logic [1:0]        rcv_q;
   logic [DATA_W-1:0] hi_q;

   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] sp_m1;
   logic [DATA_W-1:0] flags_q;
   sp_act_e           sp_act;
   logic [ADDR_W-1:0] sp_load;

   logic [1:0] nacc;
   logic [1:0] nrd;
   logic       wr_op;
   logic       rd_op;
   logic       moves_sp;
   logic       issue_go;
   logic       last_issue;
   logic       rd_ret;
   logic       final_rd;
   logic       complete;
   logic       accept;

   logic              done_q;
   logic              reg_we_q;
   logic              pc_we_q;
   logic [DATA_W-1:0] reg_out_q;
   logic [ADDR_W-1:0] pc_out_q;

   assign nacc       = op_accesses(op_q);
   assign nrd        = op_reads(op_q);
   assign sp_m1      = sp_q - ONE_A;
   assign accept     = (state_q == ST_IDLE) && cmd_valid;
   assign issue_go   = (state_q == ST_ISSUE) && (step_q < nacc);
   assign last_issue = issue_go && (step_q == nacc - 2'd1);
   assign final_rd   = rd_ret && (rcv_q == nrd - 2'd1);
   assign complete   = ((state_q == ST_ISSUE) && (nrd == 2'd0) &&
                        ((nacc == 2'd0) || last_issue)) || final_rd;

   // address, data and access kind of the current step
   always_comb begin
      mem_addr  = sp_q;
      mem_wdata = reg_q;
      wr_op     = 1'b0;
      rd_op     = 1'b0;
      moves_sp  = 1'b1;
      case (op_q)
         OP_PUSH_R: begin
            mem_addr = sp_m1;
            wr_op    = 1'b1;
         end
         OP_PUSH_F: begin
            mem_addr  = sp_m1;
            mem_wdata = flags_q;
            wr_op     = 1'b1;
         end
         OP_CALL: begin
            mem_addr  = sp_m1;
            mem_wdata = (step_q == 2'd0) ? ret_q[DATA_W-1:0]
                                         : ret_q[ADDR_W-1:DATA_W];
            wr_op     = 1'b1;
         end
         OP_POP_R, OP_POP_F, OP_RET, OP_IRET: begin
            rd_op = 1'b1;
         end
         OP_LD_REL: begin
            mem_addr = sp_q + ADDR_W'(imm_q);
            rd_op    = 1'b1;
            moves_sp = 1'b0;
         end
         OP_ST_REL: begin
            mem_addr = sp_q + ADDR_W'(imm_q);
            wr_op    = 1'b1;
            moves_sp = 1'b0;
         end
         default: begin
            moves_sp = 1'b0;
         end
      endcase
   end

   assign mem_we = issue_go && wr_op;
   assign mem_re = issue_go && rd_op;

   always_comb begin
      sp_act  = SP_HOLD;
      sp_load = {reg_q, {DATA_W{1'b0}}};
      if (issue_go && moves_sp && wr_op) begin
         sp_act = SP_DEC;
      end else if (issue_go && moves_sp && rd_op) begin
         sp_act = SP_INC;
      end else if ((state_q == ST_ISSUE) && (op_q == OP_XCHG)) begin
         sp_act = SP_LOAD;
      end
   end

   stk_sp_reg #(.ADDR_W(ADDR_W)) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (sp_act),
      .load_val (sp_load),
      .sp_q     (sp_q)
   );

   stk_flag_reg #(
      .DATA_W  (DATA_W),
      .IE_BIT  (IE_BIT),
      .RST_VAL (FLAG_RST)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (final_rd && (op_q == OP_POP_F)),
      .load_val (mem_rdata),
      .set_ie   (final_rd && (op_q == OP_IRET)),
      .flags_q  (flags_q)
   );

   stk_rd_pipe #(.RD_LAT(RD_LAT)) u_rdp (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (mem_re),
      .ret_vld (rd_ret)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_NOP;
         reg_q   <= '0;
         imm_q   <= '0;
         ret_q   <= '0;
         step_q  <= '0;
         rcv_q   <= '0;
         hi_q    <= '0;
      end else begin
         if (accept) begin
            op_q   <= stk_op_e'(cmd_op);
            reg_q  <= cmd_reg;
            imm_q  <= cmd_imm;
            ret_q  <= cmd_ret;
            step_q <= '0;
            rcv_q  <= '0;
         end else begin
            if (issue_go) step_q <= step_q + 2'd1;
            if (rd_ret)   rcv_q  <= rcv_q + 2'd1;
         end
         if (rd_ret && (rcv_q == 2'd0)) hi_q <= mem_rdata;
         case (state_q)
            ST_IDLE:  if (accept) state_q <= ST_ISSUE;
            ST_ISSUE: begin
               if (complete)        state_q <= ST_IDLE;
               else if (last_issue) state_q <= ST_DRAIN;
            end
            ST_DRAIN: if (final_rd) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   // result strobes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q    <= 1'b0;
         reg_we_q  <= 1'b0;
         pc_we_q   <= 1'b0;
         reg_out_q <= '0;
         pc_out_q  <= '0;
      end else begin
         done_q   <= complete;
         reg_we_q <= complete && ((op_q == OP_POP_R) || (op_q == OP_LD_REL) ||
                                  (op_q == OP_XCHG));
         pc_we_q  <= complete && ((op_q == OP_RET) || (op_q == OP_IRET));
         if (complete) begin
            reg_out_q <= (op_q == OP_XCHG) ? sp_q[ADDR_W-1:DATA_W] : mem_rdata;
            pc_out_q  <= {hi_q, mem_rdata};
         end
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign reg_we    = reg_we_q;
   assign pc_we     = pc_we_q;
   assign reg_out   = reg_out_q;
   assign pc_out    = pc_out_q;
   assign flags_out = flags_q;
   assign sp_out    = sp_q;

   // R11
   done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy);

   // R3
   call_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && (op_q == OP_CALL) && (step_q == 2'd1)) |->
      (mem_addr == $past(mem_addr) - ONE_A));

   // R7
   rel_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_ISSUE) && ((op_q == OP_LD_REL) || (op_q == OP_ST_REL)))
      |=> $stable(sp_q));

   // R5
   iret_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && (op_q == OP_IRET)) |-> flags_q[IE_BIT]);

endmodule

// File: tb/stk_unit_tb.sv
module stk_unit_tb;

   localparam int DW = 8;
   localparam int AW = 16;
   localparam int LAT = 2;

   localparam logic [3:0] K_REG = 4'd0, K_PC = 4'd1, K_MEMAT = 4'd2,
                          K_CALL = 4'd3, K_MEMIMM = 4'd4, K_FLAGS = 4'd5;

   // {op, reg, imm, ret, exp_sp, exp_val, kind, req}
   localparam int NV = 22;
   localparam logic [75:0] VEC [0:NV-1] = '{
      {4'd8,  8'h02, 8'h00, 16'h0000, 16'h0200, 16'h0000, K_REG,    4'd6},  // R6
      {4'd1,  8'hA5, 8'h00, 16'h0000, 16'h01FF, 16'h00A5, K_MEMAT,  4'd1},  // R1
      {4'd1,  8'h3C, 8'h00, 16'h0000, 16'h01FE, 16'h003C, K_MEMAT,  4'd1},  // R1
      {4'd5,  8'h00, 8'h00, 16'h1234, 16'h01FC, 16'h1234, K_CALL,   4'd3},  // R3
      {4'd9,  8'h00, 8'h02, 16'h0000, 16'h01FC, 16'h003C, K_REG,    4'd7},  // R7
      {4'd10, 8'h77, 8'h03, 16'h0000, 16'h01FC, 16'h0077, K_MEMIMM, 4'd7},  // R7
      {4'd6,  8'h00, 8'h00, 16'h0000, 16'h01FE, 16'h1234, K_PC,     4'd4},  // R4 R12
      {4'd2,  8'h00, 8'h00, 16'h0000, 16'h01FF, 16'h003C, K_REG,    4'd2},  // R2
      {4'd2,  8'h00, 8'h00, 16'h0000, 16'h0200, 16'h0077, K_REG,    4'd2},  // R2
      {4'd3,  8'h00, 8'h00, 16'h0000, 16'h01FF, 16'h0010, K_MEMAT,  4'd9},  // R9
      {4'd1,  8'h2D, 8'h00, 16'h0000, 16'h01FE, 16'h002D, K_MEMAT,  4'd1},  // R1
      {4'd4,  8'h00, 8'h00, 16'h0000, 16'h01FF, 16'h002D, K_FLAGS,  4'd9},  // R9
      {4'd1,  8'hCD, 8'h00, 16'h0000, 16'h01FE, 16'h00CD, K_MEMAT,  4'd1},  // R1
      {4'd1,  8'hAB, 8'h00, 16'h0000, 16'h01FD, 16'h00AB, K_MEMAT,  4'd1},  // R1
      {4'd7,  8'h00, 8'h00, 16'h0000, 16'h01FF, 16'hABCD, K_PC,     4'd5},  // R5
      {4'd0,  8'h00, 8'h00, 16'h0000, 16'h01FF, 16'h003D, K_FLAGS,  4'd5},  // R5 R11
      {4'd8,  8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0001, K_REG,    4'd6},  // R6
      {4'd1,  8'h5A, 8'h00, 16'h0000, 16'hFFFF, 16'h005A, K_MEMAT,  4'd10}, // R10
      {4'd2,  8'h00, 8'h00, 16'h0000, 16'h0000, 16'h005A, K_REG,    4'd10}, // R10
      {4'd8,  8'hFF, 8'h00, 16'h0000, 16'hFF00, 16'h0000, K_REG,    4'd6},  // R6
      {4'd10, 8'h99, 8'hFF, 16'h0000, 16'hFF00, 16'h0099, K_MEMIMM, 4'd7},  // R7
      {4'd9,  8'h00, 8'hFF, 16'h0000, 16'hFF00, 16'h0099, K_REG,    4'd7}   // R7
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [3:0]    cmd_op = '0;
   logic [DW-1:0] cmd_reg = '0;
   logic [DW-1:0] cmd_imm = '0;
   logic [AW-1:0] cmd_ret = '0;
   logic          busy, done, reg_we, pc_we, mem_we, mem_re;
   logic [DW-1:0] reg_out, flags_out, mem_wdata, mem_rdata;
   logic [AW-1:0] pc_out, sp_out, mem_addr;

   logic [7:0] mem [0:4095];
   logic [7:0] rpipe [0:LAT-1];

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] got_reg;
   logic          got_reg_we;
   logic [AW-1:0] got_pc;
   logic          got_pc_we;
   logic          got_done;

   always #2.5 clk = ~clk;

   stk_unit #(.DATA_W(DW), .ADDR_W(AW), .IE_BIT(4), .RD_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_reg(cmd_reg), .cmd_imm(cmd_imm), .cmd_ret(cmd_ret),
      .busy(busy), .done(done), .reg_out(reg_out), .reg_we(reg_we),
      .pc_out(pc_out), .pc_we(pc_we), .flags_out(flags_out), .sp_out(sp_out),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_rdata(mem_rdata)
   );

   // memory model: 4096 bytes aliased on the low address bits
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_re) rpipe[0] <= mem[mem_addr[11:0]];
      for (int i = 1; i < LAT; i++) rpipe[i] <= rpipe[i-1];
   end
   assign mem_rdata = rpipe[LAT-1];

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [7:0] rv,
                         input logic [7:0] iv, input logic [15:0] retv);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_reg = rv; cmd_imm = iv; cmd_ret = retv;
      @(negedge clk);
      cmd_valid = 1'b0;
      got_done = 1'b0;
      for (int n = 0; n < 20 && !got_done; n++) begin
         if (done) begin
            got_done = 1'b1; got_reg = reg_out; got_reg_we = reg_we;
            got_pc = pc_out; got_pc_we = pc_we;
         end else begin
            @(negedge clk);
         end
      end
      check("R11", "done seen", {15'd0, got_done}, 16'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R11 watchdog expired: actual 0x0000 expected 0x0001");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8", "sp", sp_out, 16'h0000);
      check("R8", "flags", {8'd0, flags_out}, 16'h0010);
      check("R8", "strobes", {10'd0, busy, done, reg_we, pc_we, mem_we, mem_re}, 16'd0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [75:0] e;
         string r;
         logic [15:0] a16;
         e = VEC[v];
         r = $sformatf("R%0d", e[3:0]);
         run_op(e[75:72], e[71:64], e[63:56], e[55:40]);
         check(r, $sformatf("vec %0d sp", v), sp_out, e[39:24]);
         case (e[7:4])
            K_REG: begin
               check(r, "reg_we", {15'd0, got_reg_we}, 16'd1);
               check(r, "reg_out", {8'd0, got_reg}, e[23:8]);
            end
            K_PC: begin
               check(r, "pc_we", {15'd0, got_pc_we}, 16'd1);
               check(r, "pc_out", got_pc, e[23:8]);
            end
            K_MEMAT: check(r, "mem[sp]", {8'd0, mem[sp_out[11:0]]}, e[23:8]);
            K_CALL: begin
               a16 = sp_out + 16'd1;
               check(r, "return bytes", {mem[sp_out[11:0]], mem[a16[11:0]]}, e[23:8]);
            end
            K_MEMIMM: begin
               a16 = sp_out + {8'd0, e[63:56]};
               check(r, "mem[sp+imm]", {8'd0, mem[a16[11:0]]}, e[23:8]);
            end
            default: check(r, "flags", {8'd0, flags_out}, e[23:8]);
         endcase
      end

      // R11: a command offered while busy is dropped
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 4'd5; cmd_ret = 16'h4321; cmd_reg = 8'h00;
      @(negedge clk);
      cmd_op = 4'd8; cmd_reg = 8'h11;
      check("R11", "busy during call", {15'd0, busy}, 16'd1);
      got_done = 1'b0;
      for (int n = 0; n < 20 && !got_done; n++) begin
         if (done) begin
            got_done = 1'b1;
            cmd_valid = 1'b0;
            check("R11", "no reg_we on call", {15'd0, reg_we}, 16'd0);
         end else begin
            @(negedge clk);
         end
      end
      cmd_valid = 1'b0;
      check("R11", "done seen", {15'd0, got_done}, 16'd1);
      @(negedge clk);
      check("R11", "done one cycle", {15'd0, done}, 16'd0);
      repeat (4) @(negedge clk);
      check("R11", "sp after dropped exchange", sp_out, 16'hFEFE);
      check("R3", "call low byte", {8'd0, mem[12'hEFF]}, 16'h0021);
      check("R3", "call high byte", {8'd0, mem[12'hEFE]}, 16'h0043);

      // R11: unused code only completes
      run_op(4'd13, 8'h44, 8'h00, 16'h0000);
      check("R11", "code 13 reg_we", {15'd0, got_reg_we}, 16'd0);
      check("R11", "code 13 sp", sp_out, 16'hFEFE);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule